// File: doc/BRIEF.md
# Streaming CRC-32 Generator and Checker

This block computes a 32-bit cyclic redundancy code over a message that arrives as a stream of beats. Each beat is either a whole byte or a single bit, and the kind of beat is chosen per beat, so a message can be fed a byte at a time with a few loose bits at the end. The remainder register is updated in the clock cycle of each accepted beat. Both bit orders are supported. In the most-significant-first order the incoming data enters at the top of the remainder, and the normal polynomial is used. In the least-significant-first order it enters at the bottom, and the reflected polynomial is used.

The incoming data is XORed into the remainder before the conditional shift-and-subtract steps. Because of that, the remainder after the last data beat already is the code, and no trailing zero beats are needed. A start pulse reloads the remainder with all ones. A finish pulse latches the complemented remainder as the result, and it also latches a pass flag. The pass flag tells whether the raw remainder equals the residue expected after a message followed by its own appended code. The same engine therefore serves as generator and as receiver-side checker.

Top module: `crc32_stream_engine`

## Requirements
- R1: Reset drives `crc_out` and `check_pass` to 0 and loads the remainder with all ones. A `start` pulse also reloads all ones, and any `data_valid` beat in the same cycle is ignored. Start followed directly by finish yields `crc_out` = 0x00000000.
- R2: With `lsb_first`=0 and `bit_mode`=1, a beat XORs `data_in[0]` into remainder bit 31 and then shifts left by one. The polynomial 0x04C11DB7 is XORed in when bit 31 was set. A message fed this way, 8 bits per byte with the most significant bit first, gives the same code as byte feeding.
- R3: With `lsb_first`=1 and `bit_mode`=1, a beat XORs `data_in[0]` into remainder bit 0 and then shifts right by one. The reflected polynomial 0xEDB88320 is XORed in when bit 0 was set. Bits are fed least significant first.
- R4: With `bit_mode`=0, the byte is XORed into bits 31..24 (`data_in[7]` at bit 31) when `lsb_first`=0, or into bits 7..0 when `lsb_first`=1. Eight shift steps then complete in that single cycle. ASCII "123456789" gives 0xFC891918 (`lsb_first`=0) and 0xCBF43926 (`lsb_first`=1).
- R5: No padding beats are required. The code is available at the next finish after the last data beat. A single zero byte with `lsb_first`=1 gives 0xD202EF8D.
- R6: Byte beats and bit beats may be mixed in one message, and the result equals the all-byte result for the same bit sequence.
- R7: `crc_out` is the bitwise complement of the remainder and updates only on the clock edge that samples `finish`. It holds its value at all other times.
- R8: `check_pass` is updated at finish to 1 exactly when the raw remainder equals the residue. The residue is 0xC704DD7B for `lsb_first`=0 and 0xDEBB20E3 for `lsb_first`=1. The appended code goes most significant byte first for `lsb_first`=0 and least significant byte first for `lsb_first`=1.
- R9: Cycles with `data_valid`=0 and `start`=0 leave the remainder unchanged.
- R10: A data beat presented in the same cycle as `finish` is included in the latched result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Reload remainder with all ones; beats ignored this cycle |
| data_valid | input | 1 | Beat present on `data_in` |
| data_in | input | 8 | Byte, or single bit in bit 0 when `bit_mode`=1 |
| bit_mode | input | 1 | 1 = one-bit beat, 0 = byte beat |
| lsb_first | input | 1 | 1 = reflected (least-significant-first) order, 0 = normal order |
| finish | input | 1 | Latch result and pass flag from the remainder after this cycle's beat |
| crc_out | output | 32 | Complemented remainder latched at finish |
| check_pass | output | 1 | Remainder matched the residue at finish |

## Verification
On every cycle the assertions check the following. A start reloads all ones. Idle cycles keep the remainder. The outputs move only after a finish. The latched code and pass flag agree with the remainder that reached the result register. The bench's scenarios are what show that the shift direction, the polynomial, the byte placement and the bit ordering are right. It compares against the standard check values and against its own bitwise model. It also covers bit and byte beats mixed in one message, the appended-code residue in both orders, and the handling of a corrupted message.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;

    typedef logic [CRC_W-1:0]  crc_word_t;
    typedef logic [BYTE_W-1:0] crc_byte_t;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } bit_order_e;

    typedef struct packed {
        logic       valid;
        logic       bit_mode;
        bit_order_e order;
        crc_byte_t  data;
    } crc_beat_t;

    // One conditional shift-and-subtract step (input already merged).
    function automatic crc_word_t crc_shift1(input crc_word_t rem,
                                             input crc_word_t poly,
                                             input bit_order_e order);
        crc_word_t r;
        if (order == ORDER_LSB) begin
            r = rem >> 1;
            if (rem[0]) r = r ^ poly;
        end else begin
            r = rem << 1;
            if (rem[CRC_W-1]) r = r ^ poly;
        end
        return r;
    endfunction

    // Place a beat's data where the chosen order consumes it first.
    function automatic crc_word_t crc_merge(input crc_beat_t beat);
        crc_word_t m;
        m = '0;
        if (beat.bit_mode) begin
            if (beat.order == ORDER_LSB) m[0] = beat.data[0];
            else                          m[CRC_W-1] = beat.data[0];
        end else begin
            if (beat.order == ORDER_LSB) m[BYTE_W-1:0] = beat.data;
            else                          m[CRC_W-1 -: BYTE_W] = beat.data;
        end
        return m;
    endfunction

endpackage

// File: rtl/crc_step_unit.sv
module crc_step_unit
    import crc_eng_pkg::*;
#(
    parameter crc_word_t POLY_MSB = 32'h04C1_1DB7,
    parameter crc_word_t POLY_LSB = 32'hEDB8_8320,
    parameter int        STEPS    = BYTE_W
) (
    input  crc_word_t rem_i,
    input  crc_beat_t beat_i,
    output crc_word_t rem_o
);
    crc_word_t poly;
    crc_word_t stage [0:STEPS];

    assign poly     = (beat_i.order == ORDER_LSB) ? POLY_LSB : POLY_MSB;
    assign stage[0] = rem_i ^ crc_merge(beat_i);

    for (genvar k = 0; k < STEPS; k++) begin : g_shift
        assign stage[k+1] = crc_shift1(stage[k], poly, beat_i.order);
    end

    assign rem_o = beat_i.bit_mode ? stage[1] : stage[STEPS];
endmodule

// File: rtl/crc_rem_reg.sv
module crc_rem_reg
    import crc_eng_pkg::*;
#(
    parameter crc_word_t INIT_VAL = '1
) (
    input  logic      clk,
    input  logic      rst,
    input  crc_word_t next_i,
    output crc_word_t rem_o
);
    always_ff @(posedge clk) begin
        if (rst) rem_o <= INIT_VAL;
        else     rem_o <= next_i;
    end
endmodule

// File: rtl/crc_result_reg.sv
module crc_result_reg
    import crc_eng_pkg::*;
#(
    parameter bit INVERT_OUT = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      capture_i,
    input  crc_word_t rem_i,
    input  crc_word_t residue_i,
    output crc_word_t crc_o,
    output logic      pass_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            crc_o  <= '0;
            pass_o <= 1'b0;
        end else if (capture_i) begin
            crc_o  <= INVERT_OUT ? ~rem_i : rem_i;
            pass_o <= (rem_i == residue_i);
        end
    end
endmodule

// File: rtl/crc32_stream_engine.sv
module crc32_stream_engine
    import crc_eng_pkg::*;
#(
    parameter crc_word_t POLY_MSB    = 32'h04C1_1DB7,
    parameter crc_word_t POLY_LSB    = 32'hEDB8_8320,
    parameter crc_word_t INIT_VAL    = 32'hFFFF_FFFF,
    parameter bit        INVERT_OUT  = 1'b1,
    parameter crc_word_t RESIDUE_MSB = 32'hC704_DD7B,
    parameter crc_word_t RESIDUE_LSB = 32'hDEBB_20E3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              data_valid,
    input  logic [7:0]        data_in,
    input  logic              bit_mode,
    input  logic              lsb_first,
    input  logic              finish,
    output logic [31:0]       crc_out,
    output logic              check_pass
);
    localparam crc_word_t RES_MSB_EFF = INVERT_OUT ? RESIDUE_MSB : '0;
    localparam crc_word_t RES_LSB_EFF = INVERT_OUT ? RESIDUE_LSB : '0;

    crc_beat_t beat;
    crc_word_t rem_q;
    crc_word_t rem_step;
    crc_word_t rem_next;
    crc_word_t residue;

    assign beat.valid    = data_valid;
    assign beat.bit_mode = bit_mode;
    assign beat.order    = bit_order_e'(lsb_first);
    assign beat.data     = data_in;

    assign residue = lsb_first ? RES_LSB_EFF : RES_MSB_EFF;

    crc_step_unit #(
        .POLY_MSB (POLY_MSB),
        .POLY_LSB (POLY_LSB),
        .STEPS    (BYTE_W)
    ) u_step (
        .rem_i  (rem_q),
        .beat_i (beat),
        .rem_o  (rem_step)
    );

    always_comb begin
        if (start)           rem_next = INIT_VAL;
        else if (beat.valid) rem_next = rem_step;
        else                 rem_next = rem_q;
    end

    crc_rem_reg #(
        .INIT_VAL (INIT_VAL)
    ) u_rem (
        .clk    (clk),
        .rst    (rst),
        .next_i (rem_next),
        .rem_o  (rem_q)
    );

    crc_result_reg #(
        .INVERT_OUT (INVERT_OUT)
    ) u_res (
        .clk       (clk),
        .rst       (rst),
        .capture_i (finish),
        .rem_i     (rem_next),
        .residue_i (residue),
        .crc_o     (crc_out),
        .pass_o    (check_pass)
    );
endmodule

// File: rtl/crc32_stream_engine_chk.sv
module crc32_stream_engine_chk #(
    parameter logic [31:0] INIT_VAL    = 32'hFFFF_FFFF,
    parameter bit          INVERT_OUT  = 1'b1,
    parameter logic [31:0] RESIDUE_MSB = 32'hC704_DD7B,
    parameter logic [31:0] RESIDUE_LSB = 32'hDEBB_20E3
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        data_valid,
    input logic        finish,
    input logic        lsb_first,
    input logic [31:0] rem_q,
    input logic [31:0] crc_out,
    input logic        check_pass
);
    localparam logic [31:0] RM = INVERT_OUT ? RESIDUE_MSB : 32'h0;
    localparam logic [31:0] RL = INVERT_OUT ? RESIDUE_LSB : 32'h0;

    // R1: start reloads all ones regardless of any beat
    p_start_reload_r1: assert property (@(posedge clk) disable iff (rst)
        start |=> rem_q == INIT_VAL);

    // R9: idle cycles keep the remainder
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!start && !data_valid) |=> $stable(rem_q));

    // R7: outputs move only after a finish
    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !finish |=> ($stable(crc_out) && $stable(check_pass)));

    // R7: idle finish latches the complemented remainder
    p_out_inverse_r7: assert property (@(posedge clk) disable iff (rst)
        (finish && !start && !data_valid) |=>
            crc_out == (INVERT_OUT ? ~$past(rem_q) : $past(rem_q)));

    // R8: idle finish pass flag matches the residue comparison
    p_pass_residue_r8: assert property (@(posedge clk) disable iff (rst)
        (finish && !start && !data_valid) |=>
            check_pass == ($past(rem_q) == ($past(lsb_first) ? RL : RM)));

    // R1: start with finish yields the code of an empty message
    p_empty_code_r1: assert property (@(posedge clk) disable iff (rst)
        (finish && start) |=> crc_out == (INVERT_OUT ? ~INIT_VAL : INIT_VAL));
endmodule

bind crc32_stream_engine crc32_stream_engine_chk #(
    .INIT_VAL    (INIT_VAL),
    .INVERT_OUT  (INVERT_OUT),
    .RESIDUE_MSB (RESIDUE_MSB),
    .RESIDUE_LSB (RESIDUE_LSB)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .data_valid (data_valid),
    .finish     (finish),
    .lsb_first  (lsb_first),
    .rem_q      (rem_q),
    .crc_out    (crc_out),
    .check_pass (check_pass)
);

// File: tb/crc32_stream_engine_test.sv
`timescale 1ns/1ps
module crc32_stream_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        data_valid = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic        bit_mode = 1'b0;
    logic        lsb_first = 1'b0;
    logic        finish = 1'b0;
    logic [31:0] crc_out;
    logic        check_pass;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    crc32_stream_engine uut (
        .clk(clk), .rst(rst), .start(start), .data_valid(data_valid),
        .data_in(data_in), .bit_mode(bit_mode), .lsb_first(lsb_first),
        .finish(finish), .crc_out(crc_out), .check_pass(check_pass)
    );

    logic [7:0] msg9 [0:8] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35,
                                8'h36, 8'h37, 8'h38, 8'h39};

    // Independent bitwise model: classic long division, one bit at a time.
    function automatic logic [31:0] ref_byte(input logic [31:0] r,
                                             input logic [7:0] b,
                                             input logic lsb);
        logic [31:0] x;
        logic        inb;
        x = r;
        for (int i = 0; i < 8; i++) begin
            inb = lsb ? b[i] : b[7-i];
            if (lsb) x = ((x[0] ^ inb) ? 32'hEDB88320 : 32'h0) ^ (x >> 1);
            else     x = ((x[31] ^ inb) ? 32'h04C11DB7 : 32'h0) ^ (x << 1);
        end
        return x;
    endfunction

    task automatic check32(input string tag, input logic [31:0] act,
                           input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic begin_msg(input logic lsb);
        @(negedge clk);
        lsb_first = lsb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        data_valid = 1'b1; bit_mode = 1'b0; data_in = b;
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            data_valid = 1'b1; bit_mode = 1'b1;
            data_in = {7'b0, lsb_first ? b[i] : b[7-i]};
            @(negedge clk);
        end
        data_valid = 1'b0; bit_mode = 1'b0;
    endtask

    task automatic end_msg();
        finish = 1'b1;
        @(negedge clk);
        finish = 1'b0;
    endtask

    task automatic t_reset();
        check32("R1 reset crc_out", crc_out, 32'h0);
        check1("R1 reset check_pass", check_pass, 1'b0);
        end_msg();
        check32("R1 remainder all ones after reset", crc_out, 32'h0);
    endtask

    task automatic t_byte_std();
        begin_msg(1'b1);
        for (int i = 0; i < 9; i++) put_byte(msg9[i]);
        end_msg();
        check32("R4 lsb byte check value", crc_out, 32'hCBF43926);
        begin_msg(1'b0);
        for (int i = 0; i < 9; i++) put_byte(msg9[i]);
        end_msg();
        check32("R4 msb byte check value", crc_out, 32'hFC891918);
    endtask

    task automatic t_bits_only();
        begin_msg(1'b0);
        for (int i = 0; i < 9; i++) put_bits(msg9[i], 8);
        end_msg();
        check32("R2 msb bit-serial", crc_out, 32'hFC891918);
        begin_msg(1'b1);
        for (int i = 0; i < 9; i++) put_bits(msg9[i], 8);
        end_msg();
        check32("R3 lsb bit-serial", crc_out, 32'hCBF43926);
    endtask

    task automatic t_mixed();
        for (int o = 0; o < 2; o++) begin
            begin_msg(o[0]);
            for (int i = 0; i < 8; i++) put_byte(msg9[i]);
            put_bits(msg9[8], 8);
            end_msg();
            check32("R6 mixed byte then bit tail", crc_out,
                    o[0] ? 32'hCBF43926 : 32'hFC891918);
        end
    endtask

    task automatic t_zero_byte();
        begin_msg(1'b1);
        put_byte(8'h00);
        end_msg();
        check32("R5 single zero byte", crc_out, 32'hD202EF8D);
        begin_msg(1'b1);
        end_msg();
        check32("R1 empty message", crc_out, 32'h0);
    endtask

    task automatic t_start_ignores_valid();
        @(negedge clk);
        lsb_first = 1'b1; start = 1'b1; data_valid = 1'b1; data_in = 8'hA5;
        @(negedge clk);
        start = 1'b0; data_valid = 1'b0;
        for (int i = 0; i < 9; i++) put_byte(msg9[i]);
        end_msg();
        check32("R1 beat during start ignored", crc_out, 32'hCBF43926);
    endtask

    task automatic t_gaps_and_hold();
        logic [31:0] r;
        for (int o = 0; o < 2; o++) begin
            r = 32'hFFFFFFFF;
            begin_msg(o[0]);
            for (int i = 0; i < 16; i++) begin
                put_byte(8'(i * 37 + 5));
                r = ref_byte(r, 8'(i * 37 + 5), o[0]);
                repeat (i % 3) @(negedge clk);
            end
            end_msg();
            check32("R9 gaps leave remainder", crc_out, ~r);
        end
        put_byte(8'h77);
        put_byte(8'h12);
        check32("R7 crc_out holds without finish", crc_out, ~r);
    endtask

    task automatic t_finish_with_beat();
        begin_msg(1'b0);
        for (int i = 0; i < 8; i++) put_byte(msg9[i]);
        data_valid = 1'b1; data_in = msg9[8]; finish = 1'b1;
        @(negedge clk);
        data_valid = 1'b0; finish = 1'b0;
        check32("R10 beat with finish included", crc_out, 32'hFC891918);
    endtask

    task automatic t_check_mode();
        // lsb order: code appended low byte first
        begin_msg(1'b1);
        for (int i = 0; i < 9; i++) put_byte(msg9[i]);
        put_byte(8'h26); put_byte(8'h39); put_byte(8'hF4); put_byte(8'hCB);
        end_msg();
        check1("R8 lsb residue pass", check_pass, 1'b1);
        // msb order: code appended high byte first
        begin_msg(1'b0);
        for (int i = 0; i < 9; i++) put_byte(msg9[i]);
        put_byte(8'hFC); put_byte(8'h89); put_byte(8'h19); put_byte(8'h18);
        end_msg();
        check1("R8 msb residue pass", check_pass, 1'b1);
        // corrupted payload
        begin_msg(1'b1);
        for (int i = 0; i < 9; i++) put_byte(i == 4 ? 8'h75 : msg9[i]);
        put_byte(8'h26); put_byte(8'h39); put_byte(8'hF4); put_byte(8'hCB);
        end_msg();
        check1("R8 corrupted message fails", check_pass, 1'b0);
        // wrong order of appended code
        begin_msg(1'b0);
        for (int i = 0; i < 9; i++) put_byte(msg9[i]);
        put_byte(8'h18); put_byte(8'h19); put_byte(8'h89); put_byte(8'hFC);
        end_msg();
        check1("R8 reversed code bytes fail", check_pass, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_byte_std();
        t_bits_only();
        t_mixed();
        t_zero_byte();
        t_start_ignores_valid();
        t_gaps_and_hold();
        t_finish_with_beat();
        t_check_mode();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule